// File: doc/BRIEF.md
# Embedded-Sync Timing Code Generator

This block produces the four-word timing reference codes that mark the end and the start of active video on an embedded-sync video stream. The line controller raises a one-cycle request and says whether it wants the end-of-active code or the start-of-active code. In the same cycle it presents the field, vertical-blanking and VBI-line flags of the current line. The block then emits an all-ones word, two all-zero words and a status word on four consecutive clocks, with a valid flag.

The status word carries a TASK bit, the F, V and H flags and four protection bits. How the TASK bit is chosen depends on the protocol mode and on a VBI-enable configuration bit. In BT.656 mode a cleared TASK bit can flag VBI lines. In VIP 1.1 mode TASK always separates VBI lines from active lines. In VIP 2.0 mode TASK follows a configured value, and that value is inverted on VBI lines when VBI signalling is enabled. Line flags are captured when the request is accepted, so the caller may change them during emission. Active-video multiplexing and ancillary packets are handled elsewhere.

Top module: `trs_encoder`

## Requirements
- R1: While rst_ni is low and directly after reset, valid_o is 0 and data_o is 0.
- R2: A request accepted at a clock edge makes valid_o 1 for the next four cycles, with data_o equal to all ones, then zero, then zero, then the status word.
- R3: The status word occupies the top 8 bits of data_o, with the lower WORD_W-8 bits zero. Bit 7 is TASK, bit 6 is F, bit 5 is V, bit 4 is H, bit 3 is V^H, bit 2 is F^H, bit 1 is F^V and bit 0 is F^V^H.
- R4: H is 1 when eav_i is 1 (end-of-active code) and 0 when eav_i is 0 (start-of-active code).
- R5: A request is accepted only while valid_o is 0. A request seen during any of the four output cycles, including the last one, is ignored, so valid_o is 0 for at least one cycle between codes.
- R6: TASK, F, V and H come from the inputs present in the accepting cycle. Later changes to the inputs do not alter a code already in progress.
- R7: With mode_i = 0 (BT.656), and also with the spare value 3, TASK is 0 only when vbi_en_i and vbi_line_i are both 1, and is 1 otherwise.
- R8: With mode_i = 1 (VIP 1.1), TASK is the inverse of vbi_line_i, and vbi_en_i has no effect.
- R9: With mode_i = 2 (VIP 2.0), TASK equals task_cfg_i, except that it is the inverse of task_cfg_i when vbi_en_i and vbi_line_i are both 1.
- R10: Outside the four output cycles, valid_o is 0 and data_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Protocol mode: 0 BT.656, 1 VIP 1.1, 2 VIP 2.0, 3 as 0 |
| vbi_en_i | input | 1 | Enables VBI signalling through TASK |
| task_cfg_i | input | 1 | Configured TASK value for VIP 2.0 mode |
| field_i | input | 1 | F flag of the current line |
| vblank_i | input | 1 | V flag of the current line |
| vbi_line_i | input | 1 | Current line carries VBI data |
| req_i | input | 1 | Request to emit a timing code |
| eav_i | input | 1 | 1 selects the end-of-active code, 0 the start-of-active code |
| valid_o | output | 1 | data_o holds a code word |
| data_o | output | WORD_W | Output word |

## Verification
The bench builds the block with WORD_W at its default of 8, so the status word fills the whole output and every one of its bits, the protection bits included, is compared directly. Directed codes cover every combination of mode, VBI enable, task value and VBI line that decides TASK. They also cover a request held high across a whole code, which shows the forced gap, and input changes in the middle of a code. A long stretch of random flags and requests then drives all sixteen combinations of TASK, F, V and H through the status word against the cycle model.

// File: rtl/trs_pkg.sv
package trs_pkg;
  typedef enum logic [1:0] {
    MODE_BT656 = 2'd0,
    MODE_VIP11 = 2'd1,
    MODE_VIP20 = 2'd2,
    MODE_SPARE = 2'd3
  } trs_mode_e;

  typedef struct packed {
    logic task_b;
    logic f;
    logic v;
    logic h;
  } trs_flags_t;

  localparam int unsigned XY_W = 8;
  localparam int unsigned CODE_LEN = 4;
endpackage

// File: rtl/trs_task_sel.sv
module trs_task_sel
  import trs_pkg::*;
(
  input  trs_mode_e mode_i,
  input  logic      vbi_en_i,
  input  logic      task_cfg_i,
  input  logic      vbi_line_i,
  output logic      task_o
);
  logic vbi_flag;
  assign vbi_flag = vbi_en_i & vbi_line_i;

  always_comb begin
    unique case (mode_i)
      MODE_VIP11: task_o = ~vbi_line_i;                // enable bit ignored
      MODE_VIP20: task_o = task_cfg_i ^ vbi_flag;      // inverted on VBI lines
      default:    task_o = ~vbi_flag;                  // BT.656 and spare
    endcase
  end
endmodule

// File: rtl/trs_xy_build.sv
module trs_xy_build
  import trs_pkg::*;
(
  input  trs_flags_t      flags_i,
  output logic [XY_W-1:0] xy_o
);
  logic [3:0] prot;
  always_comb begin
    prot[3] = flags_i.v ^ flags_i.h;
    prot[2] = flags_i.f ^ flags_i.h;
    prot[1] = flags_i.f ^ flags_i.v;
    prot[0] = flags_i.f ^ flags_i.v ^ flags_i.h;
    xy_o    = {flags_i.task_b, flags_i.f, flags_i.v, flags_i.h, prot};
  end
endmodule

// File: rtl/trs_seq.sv
module trs_seq
  import trs_pkg::*;
#(
  parameter int unsigned WORD_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [XY_W-1:0]   xy_i,
  output logic              valid_o,
  output logic [WORD_W-1:0] data_o
);
  localparam int unsigned PAD_W = WORD_W - XY_W;
  localparam int unsigned CNT_W = $clog2(CODE_LEN);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CODE_LEN - 1);

  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;
  logic [XY_W-1:0]  xy_q;
  logic             accept;

  assign accept = req_i & ~busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      xy_q   <= '0;
    end else if (accept) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
      xy_q   <= xy_i;
    end else if (busy_q) begin
      cnt_q  <= cnt_q + 1'b1;
      if (cnt_q == LAST) busy_q <= 1'b0;
    end
  end

  always_comb begin
    data_o = '0;
    if (busy_q) begin
      if (cnt_q == '0)       data_o = '1;
      else if (cnt_q == LAST) data_o = WORD_W'(xy_q) << PAD_W;
    end
  end

  assign valid_o = busy_q;

  assert_first_word_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_o) |-> data_o == '1);

  assert_second_word_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && cnt_q == '0) |=> (valid_o && data_o == '0));

  assert_gap_after_code_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && cnt_q == LAST) |=> !valid_o);

  assert_protection_bits_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && cnt_q == LAST) |->
      (data_o[WORD_W-5] == (data_o[WORD_W-3] ^ data_o[WORD_W-4]) &&
       data_o[WORD_W-6] == (data_o[WORD_W-2] ^ data_o[WORD_W-4]) &&
       data_o[WORD_W-7] == (data_o[WORD_W-2] ^ data_o[WORD_W-3]) &&
       data_o[WORD_W-8] == (data_o[WORD_W-2] ^ data_o[WORD_W-3] ^ data_o[WORD_W-4])));

  assert_idle_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> data_o == '0);
endmodule

// File: rtl/trs_encoder.sv
module trs_encoder
  import trs_pkg::*;
#(
  parameter int unsigned WORD_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        mode_i,
  input  logic              vbi_en_i,
  input  logic              task_cfg_i,
  input  logic              field_i,
  input  logic              vblank_i,
  input  logic              vbi_line_i,
  input  logic              req_i,
  input  logic              eav_i,
  output logic              valid_o,
  output logic [WORD_W-1:0] data_o
);
  trs_flags_t      flags;
  logic            task_b;
  logic [XY_W-1:0] xy;

  trs_task_sel u_task (
    .mode_i    (trs_mode_e'(mode_i)),
    .vbi_en_i  (vbi_en_i),
    .task_cfg_i(task_cfg_i),
    .vbi_line_i(vbi_line_i),
    .task_o    (task_b)
  );

  assign flags = '{task_b: task_b, f: field_i, v: vblank_i, h: eav_i};

  trs_xy_build u_xy (
    .flags_i(flags),
    .xy_o   (xy)
  );

  trs_seq #(.WORD_W(WORD_W)) u_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (req_i),
    .xy_i   (xy),
    .valid_o(valid_o),
    .data_o (data_o)
  );

  // VIP 1.1: a VBI line never carries TASK = 1 into a started code
  assert_vip11_task_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !valid_o && mode_i == 2'd1) |-> xy[XY_W-1] == !vbi_line_i);
endmodule

// File: tb/trs_encoder_test.sv
module trs_encoder_test;
  localparam int unsigned WORD_W = 8;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic [1:0] mode_i = '0;
  logic vbi_en_i = 0, task_cfg_i = 0, field_i = 0, vblank_i = 0;
  logic vbi_line_i = 0, req_i = 0, eav_i = 0;
  logic valid_o;
  logic [WORD_W-1:0] data_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #4 clk_i = ~clk_i;

  trs_encoder #(.WORD_W(WORD_W)) uut (.*);

  function automatic logic ref_task(logic [1:0] m, logic ven, logic tc, logic vl);
    if (m == 2'd1) return !vl;
    if (m == 2'd2) return (ven && vl) ? !tc : tc;
    return !(ven && vl);
  endfunction

  function automatic logic [7:0] xy_of(logic t, logic f, logic v, logic h);
    return {t, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
  endfunction

  // cycle model: phase 0 idle, 1..4 = word index + 1
  int m_ph = 0;
  logic [7:0] m_xy = '0;
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_ph = 0;
      m_xy = '0;
    end else if (m_ph == 0) begin
      if (req_i) begin
        m_ph = 1;
        m_xy = xy_of(ref_task(mode_i, vbi_en_i, task_cfg_i, vbi_line_i),
                     field_i, vblank_i, eav_i);
      end
    end else if (m_ph == 4) m_ph = 0;
    else m_ph = m_ph + 1;
  end

  task automatic check(string tag, logic [WORD_W:0] act, logic [WORD_W:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick();
    logic [WORD_W-1:0] ed;
    logic ev;
    @(negedge clk_i);
    ev = (m_ph != 0);
    ed = (m_ph == 1) ? '1 : (m_ph == 4) ? m_xy : '0;
    check(m_ph == 0 ? "R10" : (m_ph == 4 ? "R3" : "R2"), {valid_o, data_o}, {ev, ed});
  endtask

  task automatic send(logic [1:0] m, logic ven, logic tc, logic f, logic v,
                      logic vl, logic e);
    mode_i = m; vbi_en_i = ven; task_cfg_i = tc; field_i = f;
    vblank_i = v; vbi_line_i = vl; eav_i = e; req_i = 1'b1;
    tick();
    req_i = 1'b0;
    tick(); tick(); tick();
  endtask

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog actual %0d expected <150000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check("R1", {valid_o, data_o}, '0);
    rst_ni = 1'b1;
    tick();
    check("R1", {valid_o, data_o}, '0);

    send(2'd0, 0, 0, 1, 0, 1, 1);
    check("R7", data_o, xy_of(1, 1, 0, 1)); tick();
    send(2'd0, 1, 0, 0, 1, 1, 1);
    check("R7", data_o, xy_of(0, 0, 1, 1)); tick();
    send(2'd3, 1, 1, 1, 1, 0, 0);
    check("R7", data_o, xy_of(1, 1, 1, 0)); tick();
    send(2'd1, 0, 1, 0, 0, 1, 1);
    check("R8", data_o, xy_of(0, 0, 0, 1)); tick();
    send(2'd1, 1, 0, 1, 0, 0, 1);
    check("R8", data_o, xy_of(1, 1, 0, 1)); tick();
    send(2'd2, 0, 0, 0, 0, 1, 1);
    check("R9", data_o, xy_of(0, 0, 0, 1)); tick();
    send(2'd2, 1, 0, 0, 1, 1, 0);
    check("R9", data_o, xy_of(1, 0, 1, 0)); tick();
    send(2'd2, 1, 1, 1, 0, 0, 1);
    check("R9", data_o, xy_of(1, 1, 0, 1)); tick();
    send(2'd2, 1, 1, 1, 1, 1, 0);
    check("R4", data_o[4], 1'b0); tick();
    send(2'd0, 0, 0, 0, 0, 0, 1);
    check("R4", data_o[4], 1'b1); tick();

    // R6: flags change right after acceptance
    mode_i = 2'd0; vbi_en_i = 0; field_i = 0; vblank_i = 0; vbi_line_i = 0;
    eav_i = 1; req_i = 1;
    tick();
    req_i = 0; field_i = 1; vblank_i = 1; eav_i = 0; mode_i = 2'd1; vbi_line_i = 1;
    tick(); tick(); tick();
    check("R6", data_o, xy_of(1, 0, 0, 1)); tick();

    // R5: request held high through a whole code
    mode_i = 2'd0; vbi_line_i = 0; eav_i = 1; field_i = 0; vblank_i = 0; req_i = 1;
    tick(); tick(); tick(); tick();
    tick();
    check("R5", valid_o, 1'b0);
    tick();
    check("R5", {valid_o, data_o}, {1'b1, {WORD_W{1'b1}}});
    req_i = 0;
    repeat (4) tick();

    for (int i = 0; i < 3000; i++) begin
      mode_i = 2'($urandom_range(0, 3));
      vbi_en_i = 1'($urandom_range(0, 1));
      task_cfg_i = 1'($urandom_range(0, 1));
      field_i = 1'($urandom_range(0, 1));
      vblank_i = 1'($urandom_range(0, 1));
      vbi_line_i = 1'($urandom_range(0, 1));
      eav_i = 1'($urandom_range(0, 1));
      req_i = ($urandom_range(0, 9) < 4);
      tick();
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule